// File: doc/BRIEF.md
# Debug Exception Merge and Interrupt Gate

This block sits between a processor's debug event detectors and its exception input. Five debug event sources (single step, instruction address match, data access match, breakpoint instruction and external debug request) each present a one-cycle strobe. The block folds every strobe seen in a cycle into one 5-bit cause code, where each source owns one bit. The code is registered and presented together with a valid pulse one cycle later. Causes that arrive together are reported together in one code, and no cause is dropped or ranked below another.

The block also holds the debug control/status word at byte address 0x800 of the configuration space. In that word, bit 4 lets the normal interrupt line through and bit 3 lets the non-maskable interrupt line through. Bit 14 is a read-only copy of the processor's halt indication. Both interrupt lines are gated combinationally, so a masked line is cut off in the same cycle that it rises and an enabled line adds no delay. Both enables come out of reset set, so interrupts pass through until software clears them.

Top module: `dbg_exc_gate`

## Requirements
- R1: After reset, exc_valid is 0, exc_code is 0, and a read of address 0x800 returns 0x0000_0018 while halt_in is low (both enables set, halt flag clear).
- R2: A single strobe in cycle N gives exc_valid=1 in cycle N+1, with exc_code equal to 0x01 for step_evt, 0x02 for ibrk_evt, 0x04 for dbrk_evt, 0x08 for bkpt_evt or 0x10 for dint_evt.
- R3: Strobes raised in the same cycle are combined by bitwise OR into one exc_code, with a single exc_valid pulse in the next cycle. exc_valid is 1 exactly when exc_code is nonzero.
- R4: In a cycle after one with no strobe, exc_valid is 0 and exc_code is 0.
- R5: irq_out equals irq_in AND the interrupt enable (bit 4 of the word at 0x800), with no clock delay.
- R6: nmi_out equals nmi_in AND the NMI enable (bit 3 of the word at 0x800), with no clock delay.
- R7: A write with cfg_we=1 to address 0x800 loads bits 4 and 3 from cfg_wdata. The new enables take effect from the cycle after the write edge.
- R8: Bit 14 of the word at 0x800 reads as halt_in sampled at the previous clock edge. Writes to bit 14 have no effect on it.
- R9: Every bit of the word at 0x800 other than 14, 4 and 3 reads 0. Writes to any other address change nothing, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_evt | input | 1 | Single-step event strobe |
| ibrk_evt | input | 1 | Instruction address match strobe |
| dbrk_evt | input | 1 | Data address/value match strobe |
| bkpt_evt | input | 1 | Breakpoint instruction strobe |
| dint_evt | input | 1 | External debug request strobe |
| halt_in | input | 1 | Processor halted indication |
| irq_in | input | 1 | Normal interrupt request from outside |
| nmi_in | input | 1 | Non-maskable interrupt request from outside |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 12 | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr (combinational) |
| exc_code | output | 5 | Merged debug cause code |
| exc_valid | output | 1 | Cause code valid pulse |
| irq_out | output | 1 | Gated normal interrupt to the processor |
| nmi_out | output | 1 | Gated NMI to the processor |

## Verification
The hardest situation to reach from the ports is an enable write that lands in the same cycle as a change on a live interrupt line. That cycle must still show the old gate, and the following cycle must show the new one. The stimulus goes through phases. A sparse phase sends one-hot strobes, a dense phase sends many strobes at once, and a phase heavy in writes toggles the enables at 0x800 while irq_in, nmi_in and halt_in change at random, with bit 14 set in the write data. The same phase also aims writes at 0x900, 0xA00 and random addresses, and each of those cycles is checked to leave the control word unchanged.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
    localparam int NCAUSE = 5;
    localparam int NLINE  = 2;

    // cause bit positions inside the merged code
    localparam int C_STEP = 0;
    localparam int C_IBRK = 1;
    localparam int C_DBRK = 2;
    localparam int C_BKPT = 3;
    localparam int C_DINT = 4;

    typedef logic [NCAUSE-1:0] cause_t;

    typedef struct packed {
        logic   vld;
        cause_t code;
    } exc_t;

    typedef struct packed {
        logic             halt;
        logic [NLINE-1:0] line_en;
    } ctl_t;
endpackage

// File: rtl/dbg_cause_merge.sv
module dbg_cause_merge
    import dbg_gate_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  cause_t evt,
    output cause_t code,
    output logic   vld
);
    cause_t weighted [NCAUSE];
    exc_t   st_d, st_q;

    // each source contributes its own one-hot weight
    for (genvar i = 0; i < NCAUSE; i++) begin : g_weight
        assign weighted[i] = evt[i] ? cause_t'(1) << i : '0;
    end

    always_comb begin
        cause_t acc;
        acc = '0;
        for (int i = 0; i < NCAUSE; i++) begin
            acc = acc | weighted[i];
        end
        st_d.code = acc;
        st_d.vld  = |evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code = st_q.code;
    assign vld  = st_q.vld;
endmodule

// File: rtl/dbg_ctl_regs.sv
module dbg_ctl_regs
    import dbg_gate_pkg::*;
#(
    parameter int               ADDR_W   = 12,
    parameter int               DATA_W   = 32,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 12'h800,
    parameter int               IEN_BIT  = 4,
    parameter int               NEN_BIT  = 3,
    parameter int               HALT_BIT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              halt_in,
    output ctl_t              ctl,
    output logic [DATA_W-1:0] rdata
);
    localparam int EN_POS [NLINE] = '{IEN_BIT, NEN_BIT};

    ctl_t st_d, st_q;
    logic hit;

    assign hit = (addr == CTL_ADDR);

    always_comb begin
        st_d      = st_q;
        st_d.halt = halt_in;
        if (we && hit) begin
            for (int i = 0; i < NLINE; i++) begin
                st_d.line_en[i] = wdata[EN_POS[i]];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.halt    <= 1'b0;
            st_q.line_en <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[HALT_BIT] = st_q.halt;
            for (int i = 0; i < NLINE; i++) begin
                rdata[EN_POS[i]] = st_q.line_en[i];
            end
        end
    end

    assign ctl = st_q;
endmodule

// File: rtl/dbg_irq_gate.sv
module dbg_irq_gate
    import dbg_gate_pkg::*;
(
    input  logic [NLINE-1:0] line_in,
    input  logic [NLINE-1:0] line_en,
    output logic [NLINE-1:0] line_out
);
    for (genvar i = 0; i < NLINE; i++) begin : g_line
        assign line_out[i] = line_in[i] & line_en[i];
    end
endmodule

// File: rtl/dbg_exc_gate.sv
module dbg_exc_gate
    import dbg_gate_pkg::*;
#(
    parameter int               ADDR_W   = 12,
    parameter int               DATA_W   = 32,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 12'h800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_evt,
    input  logic              ibrk_evt,
    input  logic              dbrk_evt,
    input  logic              bkpt_evt,
    input  logic              dint_evt,
    input  logic              halt_in,
    input  logic              irq_in,
    input  logic              nmi_in,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic [NCAUSE-1:0] exc_code,
    output logic              exc_valid,
    output logic              irq_out,
    output logic              nmi_out
);
    cause_t           evt;
    ctl_t             ctl;
    logic [NLINE-1:0] line_in, line_out;

    always_comb begin
        evt         = '0;
        evt[C_STEP] = step_evt;
        evt[C_IBRK] = ibrk_evt;
        evt[C_DBRK] = dbrk_evt;
        evt[C_BKPT] = bkpt_evt;
        evt[C_DINT] = dint_evt;
    end

    dbg_cause_merge u_merge (
        .clk  (clk),
        .rst_n(rst_n),
        .evt  (evt),
        .code (exc_code),
        .vld  (exc_valid)
    );

    dbg_ctl_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CTL_ADDR(CTL_ADDR)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .halt_in(halt_in),
        .ctl    (ctl),
        .rdata  (cfg_rdata)
    );

    assign line_in = {nmi_in, irq_in};

    dbg_irq_gate u_gate (
        .line_in (line_in),
        .line_en (ctl.line_en),
        .line_out(line_out)
    );

    assign irq_out = line_out[0];
    assign nmi_out = line_out[1];
endmodule

// File: rtl/dbg_exc_gate_chk.sv
module dbg_exc_gate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        step_evt,
    input logic        ibrk_evt,
    input logic        dbrk_evt,
    input logic        bkpt_evt,
    input logic        dint_evt,
    input logic        halt_in,
    input logic        irq_in,
    input logic        nmi_in,
    input logic        cfg_we,
    input logic [11:0] cfg_addr,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic [4:0]  exc_code,
    input logic        exc_valid,
    input logic        irq_out,
    input logic        nmi_out
);
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> exc_code == $past({dint_evt, bkpt_evt, dbrk_evt, ibrk_evt, step_evt}));

    p_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid == (exc_code != 5'd0));

    p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(step_evt | ibrk_evt | dbrk_evt | bkpt_evt | dint_evt)) |-> !exc_valid);

    p_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_in |-> !irq_out);

    p_nmi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_in |-> !nmi_out);

    p_mask_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(cfg_we && cfg_addr == 12'h800 && !cfg_wdata[4])) |-> !irq_out);

    p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cfg_addr == 12'h800) |-> cfg_rdata[14] == $past(halt_in));

    p_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_addr != 12'h800) |-> cfg_rdata == 32'd0) and
        ((cfg_rdata & ~32'h0000_4018) == 32'd0));
endmodule

bind dbg_exc_gate dbg_exc_gate_chk u_chk (.*);

// File: tb/dbg_exc_gate_tb.sv
`timescale 1ns/1ps
module dbg_exc_gate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_evt = 0, ibrk_evt = 0, dbrk_evt = 0, bkpt_evt = 0, dint_evt = 0;
    logic        halt_in = 0, irq_in = 0, nmi_in = 0, cfg_we = 0;
    logic [11:0] cfg_addr = 12'h800;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [4:0]  exc_code;
    logic        exc_valid, irq_out, nmi_out;

    int n_chk = 0;
    int n_bad = 0;

    // reference state
    bit       m_ien = 1, m_nen = 1, m_halt = 0;
    bit [4:0] m_code = 0;

    always #10 clk = ~clk;

    dbg_exc_gate u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit [31:0] exp_rd(input bit [11:0] a);
        bit [31:0] v = 0;
        if (a == 12'h800) begin
            v[14] = m_halt;
            v[4]  = m_ien;
            v[3]  = m_nen;
        end
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 exc_valid", 32'(exc_valid), 0);
        chk("R1 exc_code", 32'(exc_code), 0);
        chk("R1 ctl word", cfg_rdata, 32'h18);
        chk("R1 irq_out", 32'(irq_out), 0);

        for (int cyc = 0; cyc < 3000; cyc++) begin
            int phase = cyc / 1000;
            @(negedge clk);
            if (phase == 0) begin
                // sparse: at most one strobe
                int pick = $urandom_range(0, 7);
                {dint_evt, bkpt_evt, dbrk_evt, ibrk_evt, step_evt} = (pick < 5) ? 5'(1 << pick) : 5'd0;
            end else begin
                {dint_evt, bkpt_evt, dbrk_evt, ibrk_evt, step_evt} = 5'($urandom);
            end
            irq_in  = $urandom_range(0, 1);
            nmi_in  = $urandom_range(0, 1);
            halt_in = $urandom_range(0, 1);
            cfg_we  = (phase == 2) ? ($urandom_range(0, 1) == 1) : ($urandom_range(0, 9) == 0);
            case ($urandom_range(0, 5))
                0, 1, 2: cfg_addr = 12'h800;
                3:       cfg_addr = 12'h900;
                4:       cfg_addr = 12'hA00;
                default: cfg_addr = 12'($urandom);
            endcase
            cfg_wdata = $urandom | 32'h0000_4000;
            #1;
            case ($countones(m_code))
                0:       chk("R4 exc_code", 32'(exc_code), 0);
                1:       chk("R2 exc_code", 32'(exc_code), 32'(m_code));
                default: chk("R3 exc_code", 32'(exc_code), 32'(m_code));
            endcase
            chk(m_code != 0 ? "R3 exc_valid" : "R4 exc_valid", 32'(exc_valid), 32'(m_code != 0));
            chk("R5 irq_out", 32'(irq_out), 32'(irq_in & m_ien));
            chk("R6 nmi_out", 32'(nmi_out), 32'(nmi_in & m_nen));
            if (cfg_addr == 12'h800)
                chk("R7/R8 ctl word", cfg_rdata, exp_rd(cfg_addr));
            else
                chk("R9 other address", cfg_rdata, exp_rd(cfg_addr));

            @(posedge clk);
            m_code = {dint_evt, bkpt_evt, dbrk_evt, ibrk_evt, step_evt};
            m_halt = halt_in;
            if (cfg_we && cfg_addr == 12'h800) begin
                m_ien = cfg_wdata[4];
                m_nen = cfg_wdata[3];
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule